// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block runs the four-phase handshakes that reach the internal control registers of a serial-link PHY. A controller hands it one command at a time (capture an address, write a value, or read the addressed register) and the block sequences the PHY-side strobes. For each strobe it raises the line, waits until the PHY acknowledge goes high, drops the line, then waits until the acknowledge goes low. Each wait is bounded. When it is done, the block returns one response with an error flag and, for reads, the captured data.

The command side is a valid/ready channel. `cmd_ready` is high only while the block is idle, so a command that is offered while the block is busy stays pending until the block finishes. The response is a one-cycle `rsp_valid` pulse with no back-pressure: the consumer must take it in that cycle. `rsp_err` and `rsp_rdata` are held until the next response.

The acknowledge input passes through a configurable flip-flop synchronizer before it is polled. Polls are spaced by a programmable interval of clock cycles, and the number of polls per wait is also a parameter. A write whose bit 0 is set puts the PHY into reset. Such a PHY cannot answer the write strobe, so that strobe is pulsed without any acknowledge wait.

Top module: `phy_cr_master`

## Requirements
- R1: After reset all four strobes are low, `busy` and `rsp_valid` are low and `cmd_ready` is high.
- R2: A command is accepted only on a cycle where `cmd_valid` and `cmd_ready` are both high. `busy` is high and `cmd_ready` is low from the cycle after acceptance through the cycle in which `rsp_valid` is high. `rsp_valid` lasts exactly one cycle.
- R3: Op code 0 captures an address. `phy_din` takes `cmd_data`, and then capture-address is handshaked (raise, ack high, drop, ack low).
- R4: Op code 1 writes. `phy_din` takes `cmd_data`, capture-data is handshaked, and then the write strobe is handshaked, in that order.
- R5: For op code 1 with `cmd_data[0]` set, the capture-data handshake runs normally. The write strobe is then high for exactly one cycle with no acknowledge wait, and the command completes with `rsp_err` low even if the acknowledge never answers it.
- R6: Op code 2 reads. The read strobe is handshaked, and `rsp_rdata` takes `phy_dout` at the poll that first sees the acknowledge high. Commands other than reads leave `rsp_rdata` unchanged.
- R7: Each acknowledge wait samples the synchronized acknowledge every `POLL_GAP` cycles, at most `MAX_POLLS` times. If the level is still wrong at the last poll, all strobes go low and the command ends with `rsp_err` high. A wait that times out on the first strobe puts `rsp_valid` high `POLL_GAP*MAX_POLLS+1` cycles after the accepting clock edge.
- R8: At most one strobe is high at any time. No strobe is high while the block is idle, and `phy_din` does not change while a strobe is high.
- R9: Op code 3 is reserved. It completes with `rsp_err` high, raises no strobe, and leaves `rsp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 reserved |
| cmd_data | input | DW | Address or write value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command ended in a timeout or was reserved |
| rsp_rdata | output | DW | Last read value |
| busy | output | 1 | Command in progress |
| phy_din | output | DW | Data-in bus to the PHY |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_wr | output | 1 | Write strobe |
| phy_rd | output | 1 | Read strobe |
| phy_ack | input | 1 | Acknowledge from the PHY (asynchronous) |
| phy_dout | input | DW | Data-out bus from the PHY |

## Verification
The bench builds the block with `POLL_GAP=4`, `MAX_POLLS=10` and `ACK_SYNC=2`. With those values a full timeout window is only forty cycles, so the exact timeout latency, a dead acknowledge and an acknowledge stuck high can all be checked alongside many normal transactions. The two-stage synchronizer still adds real latency that every handshake has to absorb. A behavioural PHY with a random acknowledge delay of up to twelve cycles keeps every normal wait inside the window. It also holds a small register file, so random write and read-back sequences can be compared with a bench copy.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } cr_op_e;

  // strobe index inside the strobe vector
  typedef enum logic [1:0] {
    STB_CADDR = 2'd0,
    STB_CDATA = 2'd1,
    STB_WR    = 2'd2,
    STB_RD    = 2'd3
  } stb_idx_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_HI,
    S_LO,
    S_RSTP,
    S_DONE
  } cr_state_e;

  localparam int unsigned NUM_STB = 4;

endpackage

// File: rtl/phy_cr_sync.sv
module phy_cr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chain <= '0;
        end else if (STAGES == 1) begin
          chain <= d;
        end else begin
          chain <= {chain[STAGES-2:0], d};
        end
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/phy_cr_poll.sv
module phy_cr_poll #(
  parameter int unsigned GAP = 100,
  parameter int unsigned MAX = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,   // a wait is in progress
  input  logic restart,  // start a fresh wait next cycle
  input  logic ack,
  input  logic level,    // acknowledge level awaited
  output logic met,
  output logic expired
);

  localparam int unsigned IW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int unsigned PW = $clog2(MAX + 1);

  logic [IW-1:0] ivl;
  logic [PW-1:0] cnt;
  logic          tick;

  assign tick    = (ivl == IW'(GAP - 1));
  assign met     = active && tick && (ack == level);
  assign expired = active && tick && (ack != level) && (cnt == PW'(MAX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active || restart) begin
      ivl <= '0;
      cnt <= '0;
    end else if (tick) begin
      ivl <= '0;
      cnt <= cnt + 1'b1;
    end else begin
      ivl <= ivl + 1'b1;
    end
  end

  // R7: a wait never counts past its poll budget
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < PW'(MAX)));

  // R7: an expiry ends the wait, so the counters restart from zero
  a_r7_expiry_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart) |=> (cnt == '0 || !active));

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned POLL_GAP  = 100,
  parameter int unsigned MAX_POLLS = 10,
  parameter int unsigned ACK_SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          busy,
  output logic [DW-1:0] phy_din,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_wr,
  output logic          phy_rd,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_dout
);

  cr_state_e          state;
  cr_op_e             op;
  stb_idx_e           phase;
  logic [NUM_STB-1:0] stb;
  logic               rst_req;
  logic               ack_s;
  logic               waiting, level, hit, miss, restart;

  phy_cr_sync #(.STAGES(ACK_SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (phy_ack),
    .q    (ack_s)
  );

  assign waiting = (state == S_HI) || (state == S_LO);
  assign level   = (state == S_HI);
  assign restart = (state == S_HI) && hit;

  phy_cr_poll #(.GAP(POLL_GAP), .MAX(MAX_POLLS)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (waiting),
    .restart(restart),
    .ack    (ack_s),
    .level  (level),
    .met    (hit),
    .expired(miss)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op        <= OP_ADDR;
      phase     <= STB_CADDR;
      stb       <= '0;
      rst_req   <= 1'b0;
      phy_din   <= '0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op      <= cr_op_e'(cmd_op);
            rst_req <= cmd_data[0];
            rsp_err <= 1'b0;
            unique case (cr_op_e'(cmd_op))
              OP_ADDR: begin
                phy_din <= cmd_data;
                phase   <= STB_CADDR;
                state   <= S_SETUP;
              end
              OP_WRITE: begin
                phy_din <= cmd_data;
                phase   <= STB_CDATA;
                state   <= S_SETUP;
              end
              OP_READ: begin
                phase <= STB_RD;
                state <= S_SETUP;
              end
              default: begin
                rsp_err <= 1'b1;
                state   <= S_DONE;
              end
            endcase
          end
        end
        S_SETUP: begin
          stb[phase] <= 1'b1;
          state      <= S_HI;
        end
        S_HI: begin
          if (hit) begin
            stb   <= '0;
            state <= S_LO;
            if (phase == STB_RD) rsp_rdata <= phy_dout;
          end else if (miss) begin
            stb     <= '0;
            rsp_err <= 1'b1;
            state   <= S_DONE;
          end
        end
        S_LO: begin
          if (hit) begin
            if (op == OP_WRITE && phase == STB_CDATA) begin
              phase <= STB_WR;
              if (rst_req) begin
                stb[STB_WR] <= 1'b1;
                state       <= S_RSTP;
              end else begin
                state <= S_SETUP;
              end
            end else begin
              state <= S_DONE;
            end
          end else if (miss) begin
            stb     <= '0;
            rsp_err <= 1'b1;
            state   <= S_DONE;
          end
        end
        S_RSTP: begin
          stb   <= '0;
          state <= S_DONE;
        end
        default: begin
          state <= S_IDLE;
        end
      endcase
    end
  end

  assign cmd_ready    = (state == S_IDLE);
  assign busy         = (state != S_IDLE);
  assign rsp_valid    = (state == S_DONE);
  assign phy_cap_addr = stb[STB_CADDR];
  assign phy_cap_data = stb[STB_CDATA];
  assign phy_wr       = stb[STB_WR];
  assign phy_rd       = stb[STB_RD];

  // R8: strobes are mutually exclusive and quiet while idle
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(phy_cap_addr || phy_cap_data || phy_wr || phy_rd));
  // R8: data-in bus holds while any strobe is up
  a_r8_din_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cap_addr || phy_cap_data || phy_wr || phy_rd) |=> $stable(phy_din));
  // R2: response is a single-cycle pulse, busy ends right after it
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r2_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rsp_valid));
  // R5: the reset write strobe lasts one cycle
  a_r5_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phy_wr) && rst_req) |=> (!phy_wr && rsp_valid));

endmodule

// File: tb/phy_cr_master_test.sv
module phy_cr_master_test;
  localparam int DW = 16, GAP = 4, MAXP = 10, SYNC = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, rsp_valid, rsp_err, busy;
  logic [1:0] cmd_op;
  logic [DW-1:0] cmd_data, rsp_rdata, phy_din, phy_dout;
  logic phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_ack;

  phy_cr_master #(.DW(DW), .POLL_GAP(GAP), .MAX_POLLS(MAXP), .ACK_SYNC(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .busy(busy), .phy_din(phy_din), .phy_cap_addr(phy_cap_addr),
    .phy_cap_data(phy_cap_data), .phy_wr(phy_wr), .phy_rd(phy_rd), .phy_ack(phy_ack),
    .phy_dout(phy_dout));

  // ---------------- behavioural PHY ----------------
  int mode = 0;        // 0 normal, 1 never acknowledges, 2 never releases
  bit ign_wr = 1'b0;   // PHY in reset: write strobe not answered
  int dly = 0;
  int acnt;
  logic [15:0] maddr, mdata;
  logic [15:0] mem [16];
  logic [3:0] prv;
  logic tgt_raw, tgt;

  assign tgt_raw = phy_cap_addr | phy_cap_data | phy_rd | (phy_wr & ~ign_wr);
  assign tgt = (mode == 1) ? 1'b0 : (mode == 2) ? (tgt_raw | phy_ack) : tgt_raw;

  always @(posedge clk) begin
    if (!rst_n) begin
      phy_ack <= 1'b0; acnt <= 0; prv <= '0; maddr <= '0; mdata <= '0; phy_dout <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      if (tgt != phy_ack) begin
        if (acnt >= dly) begin phy_ack <= tgt; acnt <= 0; end
        else acnt <= acnt + 1;
      end else acnt <= 0;
      prv <= {phy_rd, phy_wr, phy_cap_data, phy_cap_addr};
      if (phy_cap_addr && !prv[0]) maddr <= phy_din;
      if (phy_cap_data && !prv[1]) mdata <= phy_din;
      if (phy_wr && !prv[2] && !ign_wr) mem[maddr[3:0]] <= mdata;
      if (phy_rd && !prv[3]) phy_dout <= mem[maddr[3:0]];
    end
  end

  // ---------------- strobe monitor ----------------
  int lg_n = 0;
  int lg_code [4096];
  logic [15:0] lg_din [4096];
  int wr_cyc = 0, multi_hi = 0;
  logic [3:0] mprv = '0;

  always @(negedge clk) begin
    automatic logic [3:0] s = {phy_rd, phy_wr, phy_cap_data, phy_cap_addr};
    if ($countones(s) > 1) multi_hi <= multi_hi + 1;
    if (phy_wr) wr_cyc <= wr_cyc + 1;
    for (int k = 0; k < 4; k++)
      if (s[k] && !mprv[k] && lg_n < 4096) begin
        lg_code[lg_n] = k; lg_din[lg_n] = phy_din; lg_n = lg_n + 1;
      end
    mprv <= s;
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] ref_mem [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit log_is(input int base, input int n, input int c0, input int c1);
    log_is = (n == 1) ? (lg_code[base] == c0) : (lg_code[base] == c0 && lg_code[base+1] == c1);
  endfunction

  task automatic do_cmd(input logic [1:0] op, input logic [15:0] d,
                        output bit e, output logic [15:0] rd, output int n);
    bit hold_bad = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 2000) begin
      if (!busy || cmd_ready) hold_bad = 1;
      @(negedge clk);
      n++;
    end
    e = rsp_err; rd = rsp_rdata;
    @(negedge clk);
    if (hold_bad || rsp_valid) begin
      checks++; fails++;
      $display("FAIL R2 busy/pulse actual=%0d expected=0", hold_bad);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] v, output bit ok_all);
    bit e1, e2; logic [15:0] rd; int n; int b;
    b = lg_n;
    do_cmd(2'd0, {12'd0, a}, e1, rd, n);
    do_cmd(2'd1, v, e2, rd, n);
    ok_all = !e1 && !e2 && (lg_n - b == 3) && lg_code[b] == 0 && lg_din[b] == {12'd0, a}
             && lg_code[b+1] == 1 && lg_din[b+1] == v && lg_code[b+2] == 2;
    ref_mem[a] = v;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] rd, output bit ok_all);
    bit e1, e2; int n; int b;
    b = lg_n;
    do_cmd(2'd0, {12'd0, a}, e1, rd, n);
    do_cmd(2'd2, 16'h0, e2, rd, n);
    ok_all = !e1 && !e2 && (lg_n - b == 2) && lg_code[b] == 0 && lg_code[b+1] == 3;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    bit ok, e; logic [15:0] rd, last_rd; int n, b, w0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!phy_cap_addr && !phy_cap_data && !phy_wr && !phy_rd, "R1", "strobes", 0, 0);
    chk(!busy && !rsp_valid && cmd_ready, "R1", "busy/valid/ready",
        {busy, rsp_valid, cmd_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: directed write then R6 read back
    dly = 3;
    wr_reg(4'd3, 16'hA5A4, ok);
    chk(ok, "R4", "address+write sequence", ok, 1);
    rd_reg(4'd3, rd, ok);
    chk(ok && rd == 16'hA5A4, "R6", "read back", rd, 16'hA5A4);
    last_rd = rd;

    // R3: address only, din and strobe
    b = lg_n;
    do_cmd(2'd0, 16'h0BEE, e, rd, n);
    chk(!e && lg_n - b == 1 && lg_code[b] == 0 && lg_din[b] == 16'h0BEE, "R3",
        "address capture", lg_din[b], 16'h0BEE);
    // R6: non-read leaves read data unchanged
    chk(rd == last_rd, "R6", "rdata held after address", rd, last_rd);

    // R4 R6: constrained random traffic
    for (int it = 0; it < 40; it++) begin
      automatic logic [3:0] a = 4'($urandom_range(0, 15));
      dly = $urandom_range(0, 12);
      if ($urandom_range(0, 1) == 1) begin
        wr_reg(a, 16'($urandom) & 16'hFFFE, ok);
        chk(ok, "R4", "random write", ok, 1);
      end else begin
        rd_reg(a, rd, ok);
        chk(ok && rd == ref_mem[a], "R6", "random read", rd, ref_mem[a]);
        last_rd = rd;
      end
    end

    // R9: reserved op
    b = lg_n;
    do_cmd(2'd3, 16'h1234, e, rd, n);
    chk(e && lg_n == b, "R9", "reserved op err/no strobe", {e, 8'(lg_n - b)}, 9'h100);
    chk(rd == last_rd, "R9", "rdata unchanged", rd, last_rd);

    // R5: reset write, PHY never answers the write strobe
    ign_wr = 1'b1; dly = 2;
    b = lg_n;
    do_cmd(2'd0, 16'h7F3F, e, rd, n);
    w0 = wr_cyc;
    do_cmd(2'd1, 16'h0001, e, rd, n);
    chk(!e, "R5", "reset write no error", e, 0);
    chk(wr_cyc - w0 == 1, "R5", "write strobe cycles", wr_cyc - w0, 1);
    chk(log_is(b + 1, 2, 1, 2), "R5", "capture-data then write", lg_code[b+2], 2);
    ign_wr = 1'b0;

    // R7: dead acknowledge, exact timeout latency
    mode = 1;
    do_cmd(2'd2, 16'h0, e, rd, n);
    chk(e, "R7", "dead ack error", e, 1);
    chk(n == GAP * MAXP + 1, "R7", "timeout latency", n, GAP * MAXP + 1);
    chk(!phy_rd && !busy, "R7", "strobe low and idle", {phy_rd, busy}, 0);
    chk(rd == last_rd, "R6", "rdata unchanged on failed read", rd, last_rd);
    mode = 0;
    repeat (20) @(negedge clk);

    // R7: acknowledge stuck high, low wait expires
    mode = 2; dly = 1;
    do_cmd(2'd0, 16'h0005, e, rd, n);
    chk(e, "R7", "stuck-high ack error", e, 1);
    chk(!phy_cap_addr && !busy, "R7", "strobe low after timeout", phy_cap_addr, 0);
    mode = 0;
    repeat (30) @(negedge clk);

    // recovery after timeouts
    wr_reg(4'd9, 16'h3C3C, ok);
    rd_reg(4'd9, rd, ok);
    chk(ok && rd == 16'h3C3C, "R7", "recovery read", rd, 16'h3C3C);

    // R8: strobes never overlapped
    chk(multi_hi == 0, "R8", "overlapping strobes", multi_hi, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule